// File: doc/BRIEF.md
# Logarithmic Digital Gain Stage for PCM Samples

This block scales a stream of signed PCM samples, as they leave a decimation filter, by a gain picked with an 8-bit logarithmic code. Each code step is worth 0.375 dB, so sixteen steps make one 6 dB octave. Code 175 is the unity point. Code 1 is the quietest setting at -65.25 dB, code 255 is the loudest at +30 dB, and code 0 mutes the stream. The code normally comes from a control register outside the block. That register should reset to 175 so that the path starts at unity gain.

Inside, the code is split into a whole number of octaves and a sixteenth-of-an-octave remainder. The remainder picks a 16-bit mantissa from a sixteen-entry table. The octave count sets a right shift that is applied after the multiply. Each product is rounded to nearest and clipped to the signed output range. Samples arrive with a one-cycle valid strobe and a channel tag; there is no backpressure. Results leave exactly two clocks later with the same tag.

Top module: `db_gain_stage`

## Requirements
- R1: While reset is high, and after it falls until the first result, out_valid is 0 and out_data is 0.
- R2: out_valid is 1 exactly two clock edges after an edge at which in_valid was 1, and is 0 otherwise.
- R3: out_tag equals the in_tag that went with the same sample.
- R4: A sample taken with gain_code 0 produces out_data 0, whatever the input value.
- R5: With gain_code 175 the output equals the input exactly.
- R6: For a nonzero code c, let t = c + 1, f = t mod 16, s = 26 - floor(t/16) and m = round(2^(f/16) * 32768). The output is floor((x*m + 2^(s-1)) / 2^s), which is round to nearest with ties toward plus infinity.
- R7: A result above 2^(DW-1)-1 or below -2^(DW-1) is clipped to that bound and never wraps. A nonnegative input never gives a negative output.
- R8: The gain code is used only in the cycle where in_valid is 1. Code changes in other cycles do not affect any sample.
- R9: While out_valid is 0, out_data keeps the value of the last result.
- R10: Code 255 multiplies by exactly 32. Code 1 uses s = 26 and m = 35734.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gain_code | input | 8 | Logarithmic gain code, 0.375 dB per step, 0 mutes |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DW | Signed input sample |
| in_tag | input | TAGW | Channel tag of the input sample |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_data | output | DW | Signed scaled, rounded and clipped sample |
| out_tag | output | TAGW | Channel tag of the result |

## Verification
The properties assume that in_valid, in_data, in_tag and gain_code are known and settled at every clock edge after reset. They do not assume any spacing between samples. The latency and tag properties therefore hold for back-to-back strobes as well as for isolated ones. The stimulus changes inputs only just after a rising edge. It holds in_valid low during reset, and it deliberately moves gain_code in idle cycles and in the cycle right after a sample, so that the sampling rule is exercised within those assumptions.

// File: rtl/db_gain_pkg.sv
package db_gain_pkg;
  localparam int CODE_W    = 8;
  localparam int STEP_LOG2 = 4;
  localparam int STEPS     = 1 << STEP_LOG2;
  localparam int MANT_W    = 16;
  localparam int MANT_FRAC = 15;
  localparam int SHIFT_W   = 6;

  // round(2^(f/16) * 2^15)
  function automatic logic [MANT_W-1:0] mant_lut(input logic [STEP_LOG2-1:0] f);
    logic [MANT_W-1:0] m;
    case (f)
      4'd0:  m = 16'd32768;
      4'd1:  m = 16'd34219;
      4'd2:  m = 16'd35734;
      4'd3:  m = 16'd37316;
      4'd4:  m = 16'd38968;
      4'd5:  m = 16'd40693;
      4'd6:  m = 16'd42495;
      4'd7:  m = 16'd44376;
      4'd8:  m = 16'd46341;
      4'd9:  m = 16'd48393;
      4'd10: m = 16'd50535;
      4'd11: m = 16'd52773;
      4'd12: m = 16'd55109;
      4'd13: m = 16'd57549;
      4'd14: m = 16'd60097;
      default: m = 16'd62757;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/db_gain_decode.sv
module db_gain_decode
  import db_gain_pkg::*;
#(
  parameter int UNITY_CODE = 175
) (
  input  logic [CODE_W-1:0]  code,
  output logic [MANT_W-1:0]  mant,
  output logic [SHIFT_W-1:0] shift,
  output logic               mute
);
  localparam int OCT_BIAS  = (UNITY_CODE + STEPS - 1) / STEPS;
  localparam int CODE_OFS  = OCT_BIAS * STEPS - UNITY_CODE;
  localparam int SHIFT_TOP = MANT_FRAC + OCT_BIAS;

  logic [CODE_W:0] biased;

  always_comb begin
    biased = (CODE_W+1)'(code) + (CODE_W+1)'(CODE_OFS);
    mant   = mant_lut(biased[STEP_LOG2-1:0]);
    shift  = SHIFT_W'(SHIFT_TOP - int'(biased[CODE_W:STEP_LOG2]));
    mute   = (code == '0);
  end
endmodule

// File: rtl/db_gain_mult.sv
module db_gain_mult
  import db_gain_pkg::*;
#(
  parameter int DW   = 24,
  parameter int TAGW = 3,
  parameter int PW   = DW + MANT_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic [TAGW-1:0]      in_tag,
  input  logic [MANT_W-1:0]    mant,
  input  logic [SHIFT_W-1:0]   shift,
  input  logic                 mute,
  output logic                 p_valid,
  output logic signed [PW-1:0] p_prod,
  output logic [SHIFT_W-1:0]   p_shift,
  output logic [TAGW-1:0]      p_tag
);
  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] m_ext;
  logic signed [PW-1:0] prod_c;

  always_comb begin
    a_ext  = PW'(in_data);
    m_ext  = PW'($signed({1'b0, mant}));
    prod_c = a_ext * m_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_valid <= 1'b0;
      p_prod  <= '0;
      p_shift <= '0;
      p_tag   <= '0;
    end else begin
      p_valid <= in_valid;
      if (in_valid) begin
        p_prod  <= mute ? '0 : prod_c;
        p_shift <= shift;
        p_tag   <= in_tag;
      end
    end
  end
endmodule

// File: rtl/db_gain_round_sat.sv
module db_gain_round_sat
  import db_gain_pkg::*;
#(
  parameter int DW   = 24,
  parameter int TAGW = 3,
  parameter int PW   = DW + MANT_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 p_valid,
  input  logic signed [PW-1:0] p_prod,
  input  logic [SHIFT_W-1:0]   p_shift,
  input  logic [TAGW-1:0]      p_tag,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data,
  output logic [TAGW-1:0]      out_tag
);
  localparam int RW = PW + 1;
  localparam logic signed [RW-1:0] MAXV = $signed({{(RW-DW+1){1'b0}}, {(DW-1){1'b1}}});
  localparam logic signed [RW-1:0] MINV = $signed({{(RW-DW+1){1'b1}}, {(DW-1){1'b0}}});

  logic signed [RW-1:0] half;
  logic signed [RW-1:0] sum;
  logic signed [RW-1:0] scaled;
  logic signed [DW-1:0] clip;

  always_comb begin
    half   = (p_shift == '0) ? '0 : (RW'(1) << (p_shift - SHIFT_W'(1)));
    sum    = RW'(p_prod) + half;
    scaled = sum >>> p_shift;
    if (scaled > MAXV)      clip = MAXV[DW-1:0];
    else if (scaled < MINV) clip = MINV[DW-1:0];
    else                    clip = scaled[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_tag   <= '0;
    end else begin
      out_valid <= p_valid;
      if (p_valid) begin
        out_data <= clip;
        out_tag  <= p_tag;
      end
    end
  end
endmodule

// File: rtl/db_gain_stage.sv
module db_gain_stage
  import db_gain_pkg::*;
#(
  parameter int DW         = 24,
  parameter int TAGW       = 3,
  parameter int UNITY_CODE = 175
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CODE_W-1:0]    gain_code,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic [TAGW-1:0]      in_tag,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data,
  output logic [TAGW-1:0]      out_tag
);
  localparam int PW = DW + MANT_W + 1;

  logic [MANT_W-1:0]    dec_mant;
  logic [SHIFT_W-1:0]   dec_shift;
  logic                 dec_mute;
  logic                 p_valid;
  logic signed [PW-1:0] p_prod;
  logic [SHIFT_W-1:0]   p_shift;
  logic [TAGW-1:0]      p_tag;

  db_gain_decode #(.UNITY_CODE(UNITY_CODE)) u_decode (
    .code  (gain_code),
    .mant  (dec_mant),
    .shift (dec_shift),
    .mute  (dec_mute)
  );

  db_gain_mult #(.DW(DW), .TAGW(TAGW), .PW(PW)) u_mult (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_tag   (in_tag),
    .mant     (dec_mant),
    .shift    (dec_shift),
    .mute     (dec_mute),
    .p_valid  (p_valid),
    .p_prod   (p_prod),
    .p_shift  (p_shift),
    .p_tag    (p_tag)
  );

  db_gain_round_sat #(.DW(DW), .TAGW(TAGW), .PW(PW)) u_round (
    .clk       (clk),
    .rst       (rst),
    .p_valid   (p_valid),
    .p_prod    (p_prod),
    .p_shift   (p_shift),
    .p_tag     (p_tag),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_tag   (out_tag)
  );
endmodule

// File: rtl/db_gain_stage_chk.sv
module db_gain_stage_chk #(
  parameter int DW         = 24,
  parameter int TAGW       = 3,
  parameter int UNITY_CODE = 175
) (
  input logic                 clk,
  input logic                 rst,
  input logic [7:0]           gain_code,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_data,
  input logic [TAGW-1:0]      in_tag,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_data,
  input logic [TAGW-1:0]      out_tag
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    (age < 2'd2) |-> !out_valid);

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_tag_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && out_valid) |-> (out_tag == $past(in_tag, 2)));

  assert_mute_R4: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(in_valid && gain_code == 8'd0, 2)) |-> (out_data == '0));

  assert_unity_R5: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(in_valid && gain_code == 8'(UNITY_CODE), 2))
      |-> (out_data == $past(in_data, 2)));

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(in_valid && !in_data[DW-1], 2)) |-> !out_data[DW-1]);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && !out_valid) |-> $stable(out_data));
endmodule

bind db_gain_stage db_gain_stage_chk #(.DW(DW), .TAGW(TAGW), .UNITY_CODE(UNITY_CODE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .gain_code (gain_code),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_tag    (in_tag),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_tag   (out_tag)
);

// File: tb/db_gain_stage_bench.sv
module db_gain_stage_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 24;
  localparam int TAGW = 3;
  localparam longint MAXV = (64'sd1 <<< (DW-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (DW-1));

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [7:0]           gain_code = 8'd175;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic [TAGW-1:0]      in_tag = '0;
  logic                 out_valid;
  logic signed [DW-1:0] out_data;
  logic [TAGW-1:0]      out_tag;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  string cur_req = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  db_gain_stage u_db_gain_stage (
    .clk(clk), .rst(rst), .gain_code(gain_code), .in_valid(in_valid),
    .in_data(in_data), .in_tag(in_tag), .out_valid(out_valid),
    .out_data(out_data), .out_tag(out_tag)
  );

  // Expected result from R4, R6 and R7
  function automatic longint model(int code, longint x);
    int t, f, s;
    longint m, r;
    if (code == 0) return 0;
    t = code + 1;
    f = t % 16;
    s = 26 - t / 16;
    m = longint'($rtoi((2.0 ** (f / 16.0)) * 32768.0 + 0.5));
    r = (x * m + (64'sd1 <<< (s - 1))) >>> s;
    if (r > MAXV) r = MAXV;
    if (r < MINV) r = MINV;
    return r;
  endfunction

  function automatic string req_of(int code, longint x);
    longint raw;
    if (code == 0) return "R4";
    if (code == 175) return "R5";
    if (code == 255 || code == 1) return "R10";
    raw = model(code, x);
    if (raw == MAXV || raw == MINV) return "R7";
    return "R6";
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Two-deep history of what was presented to the block
  bit h0_v, h1_v;
  int h0_code, h1_code;
  longint h0_x, h1_x;
  int h0_tag, h1_tag;
  string h0_req, h1_req;
  longint last_out = 0;

  always @(negedge clk) begin
    if (rst) begin
      check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
      check(out_data == '0, "R1", "out_data in reset", out_data, 0);
      h0_v = 0; h1_v = 0; last_out = 0;
    end else begin
      if (h1_v) begin
        longint e;
        e = model(h1_code, h1_x);
        check(out_valid == 1'b1, "R2", "out_valid after sample", out_valid, 1);
        check(int'(out_tag) == h1_tag, "R3", "out_tag", out_tag, h1_tag);
        check(longint'(out_data) == e, h1_req, "out_data", out_data, e);
        last_out = e;
      end else begin
        check(out_valid == 1'b0, "R2", "out_valid when idle", out_valid, 0);
        check(longint'(out_data) == last_out, "R9", "held out_data", out_data, last_out);
      end
      h1_v = h0_v; h1_code = h0_code; h1_x = h0_x; h1_tag = h0_tag; h1_req = h0_req;
      h0_v = in_valid; h0_code = int'(gain_code); h0_x = longint'(in_data);
      h0_tag = int'(in_tag);
      h0_req = (cur_req != "") ? cur_req : req_of(int'(gain_code), longint'(in_data));
    end
  end

  task automatic drive(int code, longint x, int tag, bit v);
    @(posedge clk);
    #1;
    gain_code = 8'(code);
    in_data   = DW'(x);
    in_tag    = TAGW'(tag);
    in_valid  = v;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(int'(gain_code), 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_errors++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240117));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    idle(3);

    // R5 unity
    cur_req = "R5";
    drive(175, 0, 1, 1); drive(175, 1, 2, 1); drive(175, -1, 3, 1);
    drive(175, MAXV, 4, 1); drive(175, MINV, 5, 1);
    // R4 mute
    cur_req = "R4";
    drive(0, MAXV, 6, 1); drive(0, MINV, 7, 1); drive(0, -12345, 0, 1);
    // R10 end points and R7 clipping
    cur_req = "R10";
    drive(255, 1000, 1, 1); drive(255, -1, 2, 1); drive(1, MAXV, 3, 1); drive(1, MINV, 4, 1);
    cur_req = "R7";
    drive(255, MAXV, 5, 1); drive(255, MINV, 6, 1); drive(200, 4000000, 7, 1);
    // R6 rounding ties at code 159 (gain 0.5)
    cur_req = "R6";
    drive(159, 3, 0, 1); drive(159, -3, 1, 1); drive(159, 1, 2, 1); drive(159, -1, 3, 1);
    idle(2);
    // R8 code moves outside valid cycles
    cur_req = "R8";
    drive(100, 700000, 2, 1);
    drive(255, 0, 0, 0); drive(0, 0, 0, 0); drive(30, 0, 0, 0);
    drive(120, -500000, 3, 1);
    drive(0, 999, 0, 0); drive(255, 999, 0, 0);
    drive(60, 3000000, 4, 1);
    drive(250, 0, 0, 0);
    idle(3);
    cur_req = "";

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      int code;
      longint x;
      bit v;
      case ($urandom % 4)
        0: code = 175 + int'($urandom % 81);
        1: code = int'($urandom % 256);
        2: code = (($urandom % 2) == 0) ? 0 : 255;
        default: code = 140 + int'($urandom % 40);
      endcase
      if (($urandom % 3) == 0) x = longint'($signed(DW'($urandom)));
      else x = longint'($urandom % 20001) - 10000;
      v = (($urandom % 10) < 7);
      drive(code, x, int'($urandom % 8), v);
    end
    idle(4);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule